// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column access request into the sequence of column addresses that a 16-bit-wide SDRAM walks through during a burst. A one-cycle start pulse carries the starting column, the burst-length code and the burst-order bit from the mode register, the single-write bit and a read/write flag. From the next clock on, the block presents one column address per beat on a valid/ready output stream. It raises a last flag on the final beat of a fixed-length burst and drops valid once that beat has been accepted.

A burst stays inside an aligned block of columns whose size equals the burst length. In sequential order the address counts up and wraps at the block edge. In interleaved order beat k uses the starting column XOR k in the block bits. The column bits above the block do not change. A full-page burst counts up through all 1024 columns, wrapping from 1023 to 0, until a terminate input stops it. Setting the single-write bit limits every write to one beat, while reads keep the programmed length and order.

Back-pressure: a beat is transferred on a clock edge where `col_valid` and `col_ready` are both high. While `col_ready` is low, the presented address and flags hold. `col_ready` may change in any cycle and has no combinational path to the outputs. A start pulse or a terminate acts on the edge where it is sampled, whether or not `col_ready` is high. If the presented beat also had `col_ready` high on that edge, that beat still counts as transferred.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `cfg_err` are all low.
- R2: After a start sampled on edge n, `col_valid` is high from edge n on, with `col_addr` equal to the starting column. A start during an active burst abandons that burst and begins the new one, and it takes priority over a terminate sampled on the same edge.
- R3: Burst-length codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats. `col_last` is high only on the final beat, and `col_valid` is low after that beat is accepted.
- R4: With order bit 0 (sequential), beat k has address block_base + ((start mod L) + k) mod L, where L is the burst length.
- R5: With order bit 1 (interleaved), beat k has address block_base + ((start mod L) XOR k).
- R6: Code 7 selects full page. The burst always runs in sequential order, wraps from column 1023 to column 0, never raises `col_last`, and continues until it is terminated.
- R7: `burst_stop` sampled high during an active burst (with no start) makes `col_valid` low from the next edge. `burst_stop` while idle has no effect.
- R8: With `wr_single` high, a write (`is_write` = 1) yields exactly one beat, at the starting column, with `col_last` high. Reads are unaffected by `wr_single`.
- R9: Reserved length codes 4, 5 and 6 run as a one-beat burst and set `cfg_err`. Full page combined with interleaved order runs sequentially and sets `cfg_err`. `cfg_err` holds until the next start, and valid codes clear it.
- R10: While `col_valid` is high and `col_ready` is low, with no start and no terminate, `col_addr`, `col_last` and `col_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a burst |
| start_col | input | 10 | Starting column address |
| bl_code | input | 3 | Burst-length code: 0..3 = 1/2/4/8 beats, 7 = full page, 4..6 reserved |
| order_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| wr_single | input | 1 | Single-write bit: writes last one beat |
| is_write | input | 1 | 1 = write access, 0 = read access |
| burst_stop | input | 1 | Burst terminate |
| col_ready | input | 1 | Consumer accepts the presented beat |
| col_valid | output | 1 | A column address is presented |
| col_addr | output | 10 | Column address of the current beat |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Configuration of the current/last burst was illegal |

## Verification
Two events can land on the same edge. A fresh start can coincide with a terminate, or with an accepted beat of the running burst. The bench provokes both by raising start and `burst_stop` together while an 8-beat burst is halfway through and `col_ready` is high. The scoreboard expects the beat shown on that edge, followed directly by the complete new burst from its own starting column, with nothing further from the old burst. A full-page burst is stopped on a chosen beat to show that a terminate coinciding with an accepted beat ends the stream right after that beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // burst-length codes that carry a fixed meaning
  localparam logic [2:0] BLC_MAX_FIXED = 3'd3;
  localparam logic [2:0] BLC_FULLPAGE  = 3'd7;

  typedef struct packed {
    logic [1:0] len_log2; // log2 of the fixed burst length
    logic       full;     // full-page burst
    logic       ilv;      // interleaved ordering in effect
    logic       err;      // illegal configuration seen
  } burst_cfg_t;

endpackage

// File: rtl/colgen_cfg_decode.sv
module colgen_cfg_decode
  import colgen_pkg::*;
(
  input  logic [2:0] bl_code,
  input  logic       order_ilv,
  input  logic       is_write,
  input  logic       wr_single,
  output burst_cfg_t cfg
);

  always_comb begin
    cfg = '0;
    if (bl_code <= BLC_MAX_FIXED) begin
      cfg.len_log2 = bl_code[1:0];
    end else if (bl_code == BLC_FULLPAGE) begin
      cfg.full = 1'b1;
      cfg.err  = order_ilv;
    end else begin
      cfg.err  = 1'b1;
    end
    cfg.ilv = order_ilv & ~cfg.full;
    if (is_write && wr_single) begin
      cfg.len_log2 = 2'd0;
      cfg.full     = 1'b0;
    end
  end

endmodule

// File: rtl/colgen_beat_ctrl.sv
module colgen_beat_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             burst_stop,
  input  logic             col_ready,
  input  logic             full_q,
  input  logic [COL_W-1:0] blk_mask,
  output logic             active,
  output logic [COL_W-1:0] beat_idx,
  output logic             last
);

  assign last = active & ~full_q & (beat_idx == blk_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beat_idx <= '0;
    end else if (start) begin
      active   <= 1'b1;
      beat_idx <= '0;
    end else if (active && burst_stop) begin
      active   <= 1'b0;
    end else if (active && col_ready) begin
      if (last) active <= 1'b0;
      else      beat_idx <= beat_idx + 1'b1;
    end
  end

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] blk_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col_addr
);

  logic [COL_W-1:0] seq_low;
  logic [COL_W-1:0] ilv_low;
  logic [COL_W-1:0] pick_low;

  assign seq_low  = base_col + beat_idx;
  assign ilv_low  = base_col ^ beat_idx;
  assign pick_low = ilv ? ilv_low : seq_low;

  // per bit: inside the block take the walked value, above it keep the start
  for (genvar b = 0; b < COL_W; b++) begin : g_merge
    assign col_addr[b] = blk_mask[b] ? pick_low[b] : base_col[b];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             order_ilv,
  input  logic             wr_single,
  input  logic             is_write,
  input  logic             burst_stop,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             cfg_err
);

  localparam logic [COL_W-1:0] ALL_ONES = '1;

  burst_cfg_t       cfg_new;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] blk_mask;
  logic [COL_W-1:0] beat_idx;
  logic             active;

  colgen_cfg_decode u_dec (
    .bl_code   (bl_code),
    .order_ilv (order_ilv),
    .is_write  (is_write),
    .wr_single (wr_single),
    .cfg       (cfg_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      cfg_q  <= cfg_new;
      base_q <= start_col;
    end
  end

  always_comb begin
    if (cfg_q.full) blk_mask = ALL_ONES;
    else            blk_mask = COL_W'((1 << cfg_q.len_log2) - 1);
  end

  colgen_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .burst_stop (burst_stop),
    .col_ready  (col_ready),
    .full_q     (cfg_q.full),
    .blk_mask   (blk_mask),
    .active     (active),
    .beat_idx   (beat_idx),
    .last       (col_last)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base_col (base_q),
    .beat_idx (beat_idx),
    .blk_mask (blk_mask),
    .ilv      (cfg_q.ilv),
    .col_addr (col_addr)
  );

  assign col_valid = active;
  assign cfg_err   = cfg_q.err;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       bl_code,
  input logic             is_write,
  input logic             wr_single,
  input logic             burst_stop,
  input logic             col_ready,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             cfg_err
);

  // R2
  start_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));

  // R3
  last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last && !start) |=> !col_valid);

  // R7
  stop_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !start) |=> !col_valid);

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && is_write && wr_single) |=> col_last);

  // R9
  reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bl_code >= 3'd4 && bl_code <= 3'd6) |=> (cfg_err && col_last));

  // R9
  legal_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && bl_code <= 3'd3) |=> !cfg_err);

  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !start && !burst_stop) |=>
      (col_valid && $stable(col_addr) && $stable(col_last)));

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] start_col = '0;
  logic [2:0] bl_code = '0;
  logic       order_ilv = 1'b0;
  logic       wr_single = 1'b0;
  logic       is_write = 1'b0;
  logic       burst_stop = 1'b0;
  logic       col_ready = 1'b1;
  logic       col_valid;
  logic [9:0] col_addr;
  logic       col_last;
  logic       cfg_err;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic done = 1'b0;

  typedef struct {
    logic [9:0] addr;
    logic       last;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .order_ilv(order_ilv), .wr_single(wr_single),
    .is_write(is_write), .burst_stop(burst_stop), .col_ready(col_ready),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int burst_len(input int code, input bit wr, input bit wbs);
    if (wr && wbs) return 1;
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  function automatic int exp_addr(input int col, input int code, input bit ilv,
                                  input bit wr, input bit wbs, input int k);
    int len, base, off;
    if (code == 7 && !(wr && wbs)) return (col + k) % 1024;
    len  = burst_len(code, wr, wbs);
    off  = col % len;
    base = col - off;
    if (ilv) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  task automatic push_beats(input int col, input int code, input bit ilv, input bit wr,
                            input bit wbs, input int n, input string req);
    int len;
    bit full;
    len  = burst_len(code, wr, wbs);
    full = (code == 7) && !(wr && wbs);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.addr = 10'(exp_addr(col, code, ilv, wr, wbs, k));
      e.last = !full && (k == len - 1);
      e.req  = req;
      q.push_back(e);
    end
  endtask

  task automatic drive_start(input int col, input int code, input bit ilv,
                             input bit wr, input bit wbs);
    start_col = 10'(col);
    bl_code   = 3'(code);
    order_ilv = ilv;
    is_write  = wr;
    wr_single = wbs;
    start     = 1'b1;
  endtask

  // full fixed-length burst, judged by the scoreboard
  task automatic run_burst(input int col, input int code, input bit ilv, input bit wr,
                           input bit wbs, input string req);
    bit exp_err;
    exp_err = (code >= 4 && code <= 6) || (code == 7 && ilv);
    push_beats(col, code, ilv, wr, wbs, burst_len(code, wr, wbs), req);
    @(negedge clk);
    drive_start(col, code, ilv, wr, wbs);
    @(negedge clk);
    start = 1'b0;
    check(cfg_err == exp_err, {req, " err flag"}, int'(cfg_err), int'(exp_err));
    while (q.size() != 0) @(negedge clk);
    check(col_valid == 1'b0, {req, " valid after burst"}, int'(col_valid), 0);
  endtask

  // burst stopped by terminate on beat m-1 (ready held high)
  task automatic run_term(input int col, input int code, input bit ilv, input int m,
                          input string req);
    bit exp_err;
    exp_err = (code == 7 && ilv);
    push_beats(col, code, ilv, 1'b0, 1'b0, m, req);
    @(negedge clk);
    drive_start(col, code, ilv, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b0;
    check(cfg_err == exp_err, {req, " err flag"}, int'(cfg_err), int'(exp_err));
    repeat (m - 1) @(negedge clk);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    check(col_valid == 1'b0, "R7 valid after terminate", int'(col_valid), 0);
    check(q.size() == 0, "R7 beats left in queue", q.size(), 0);
  endtask

  // ready generator
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      col_ready = stall_en ? lfsr[0] : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    bit         was_stalled = 1'b0;
    logic [9:0] held_addr = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && col_valid) begin
        if (was_stalled)
          check(col_addr == held_addr, "R10 address held under stall",
                int'(col_addr), int'(held_addr));
        if (col_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R3 unexpected beat", int'(col_addr), -1);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(col_addr == e.addr, {e.req, " address"}, int'(col_addr), int'(e.addr));
            check(col_last == e.last, {e.req, " last flag"}, int'(col_last), int'(e.last));
          end
          was_stalled = 1'b0;
        end else begin
          was_stalled = 1'b1;
          held_addr   = col_addr;
        end
      end else begin
        was_stalled = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(col_valid == 1'b0, "R1 valid", int'(col_valid), 0);
    check(col_last == 1'b0, "R1 last", int'(col_last), 0);
    check(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);

    // R3 R4 sequential lengths and block wrap
    run_burst(6, 2, 1'b0, 1'b0, 1'b0, "R4 seq bl4");
    run_burst(9, 0, 1'b0, 1'b0, 1'b0, "R3 bl1");
    run_burst(7, 1, 1'b0, 1'b0, 1'b0, "R3 bl2");
    stall_en = 1'b1;
    run_burst(13, 3, 1'b0, 1'b0, 1'b0, "R4 seq bl8 stalled");
    // R5 interleaved
    run_burst(21, 3, 1'b1, 1'b0, 1'b0, "R5 ilv bl8");
    run_burst(514, 2, 1'b1, 1'b0, 1'b0, "R5 ilv bl4");
    run_burst(7, 1, 1'b1, 1'b0, 1'b0, "R5 ilv bl2");
    // R8 single-write bit
    run_burst(45, 3, 1'b0, 1'b1, 1'b1, "R8 write single");
    run_burst(45, 3, 1'b0, 1'b0, 1'b1, "R8 read keeps length");
    run_burst(45, 2, 1'b1, 1'b1, 1'b0, "R8 write full length");
    // R9 reserved codes
    run_burst(300, 5, 1'b0, 1'b0, 1'b0, "R9 reserved code 5");
    run_burst(301, 4, 1'b1, 1'b0, 1'b0, "R9 reserved code 4");
    run_burst(302, 3, 1'b0, 1'b0, 1'b0, "R9 err cleared");
    stall_en = 1'b0;

    // R6 full page wrap, stopped by terminate
    run_term(1020, 7, 1'b0, 6, "R6 full page wrap");
    // R9 full page with interleave runs sequential
    run_term(3, 7, 1'b1, 3, "R9 full page ilv");
    // R7 terminate mid fixed burst
    run_term(40, 3, 1'b0, 2, "R7 stop bl8");

    // R7 terminate while idle
    @(negedge clk);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    check(col_valid == 1'b0, "R7 idle stop valid", int'(col_valid), 0);
    @(negedge clk);
    check(col_valid == 1'b0, "R7 idle stop stays idle", int'(col_valid), 0);

    // R2 restart mid burst, start together with terminate
    push_beats(5, 3, 1'b0, 1'b0, 1'b0, 3, "R2 first burst");
    @(negedge clk);
    drive_start(5, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    push_beats(100, 2, 1'b1, 1'b0, 1'b0, 4, "R2 restarted burst");
    drive_start(100, 2, 1'b1, 1'b0, 1'b0);
    burst_stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    burst_stop = 1'b0;
    check(col_valid == 1'b1, "R2 new burst valid", int'(col_valid), 1);
    check(col_addr == 10'd100, "R2 new burst first column", int'(col_addr), 100);
    while (q.size() != 0) @(negedge clk);
    check(col_valid == 1'b0, "R2 valid after restarted burst", int'(col_valid), 0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule